// File: doc/BRIEF.md
# Glitch-Free Two-Clock Switch

This block picks one of two unrelated input clocks, A and B, and passes it to its output without any runt pulse or glitch. A select input chooses B when high and A when low. Each clock has its own lane, clocked on that clock's falling edge. A lane re-times the select and the other lane's busy state, then walks a small state machine. Its gate opens only after the other lane has gone idle and a fixed parking count has passed. Before the gate closes, a short drain runs. Both gates change only while their clock is low, so the output never carries a partial pulse.

A companion loss detector provides a "stopped" flag for each clock. When the outgoing clock is flagged and is no longer selected, its lane is cleared at once. That clock would never produce the falling edges that the normal handshake needs. The output therefore drops immediately, and the incoming lane parks for its own count before the new clock appears. The output is copied onto two outputs, and each copy has its own enable that holds it low.

Lane states: IDLE (gate closed, not claimed), PARK (claimed, counting cycles with the gate closed), RUN (gate open), DRAIN (selection lost, gate still open). The lane moves through these transitions:
- IDLE to PARK: the lane is wanted and the other lane is idle.
- PARK to IDLE: the lane is no longer wanted, or the other lane is busy.
- PARK to RUN: the park count is complete.
- RUN to DRAIN: the lane is no longer wanted.
- DRAIN to RUN: the lane is wanted again.
- DRAIN to IDLE: the drain count is complete.

Top module: `clk_switch2`

## Requirements
- R1: When settled, with `pick_b`=1 each enabled copy equals `clk_b`, and with `pick_b`=0 each enabled copy equals `clk_a`.
- R2: While `rst_n` is low, both copies are 0. After release, the clock named by `pick_b` first appears no sooner than PARK_CYCLES periods of that clock.
- R3: The output never shows a high or low pulse shorter than the shorter half-period of the two inputs.
- R4: Between the last pulse of the old clock and the first pulse of the new one, the output stays low for at least PARK_CYCLES periods of the new clock.
- R5: If the outgoing clock is flagged stopped, whether it stopped high or low, the output is 0 immediately after the select changes, with no edge of that clock needed.
- R6: The two lane gates are never open at the same time. A previously stopped clock that restarts while it is unselected never reaches the output.
- R7: Each copy `copy_clk[i]` is 0 whenever `copy_en[i]` is 0, and the other copy is unaffected.
- R8: The width of each high output pulse equals the high time of the selected input.
- R9: A lane's gate opens only after PARK_CYCLES consecutive falling edges in PARK.
- R10: With both clocks running, the outgoing clock keeps reaching the output for at least SYNC_STAGES of its periods after the select changes. Once its lane sees the change, its gate stays open for one more cycle (DRAIN).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Input clock A |
| clk_b | input | 1 | Input clock B |
| rst_n | input | 1 | Asynchronous active-low reset |
| pick_b | input | 1 | Select: 1 chooses B, 0 chooses A |
| a_stopped | input | 1 | Loss flag for clock A from the detector |
| b_stopped | input | 1 | Loss flag for clock B from the detector |
| copy_en | input | NUM_OUT | Per-copy enable, active high |
| copy_clk | output | NUM_OUT | Switched clock copies, low when disabled |

## Verification
The delicate case is a stop flag that coincides with a select change. The flag clears the outgoing lane asynchronously in the same instant that the incoming lane begins to see it as idle and starts parking. The bench provokes this by freezing one clock at a high level or a low level, raising its flag, and then flipping the select. One nanosecond later it requires a zero output. It then measures the low gap before the new clock's first pulse and checks that the revived clock never leaks back to the output.

// File: rtl/clkmux_pkg.sv
package clkmux_pkg;
    typedef enum logic [1:0] {
        LANE_IDLE  = 2'd0,
        LANE_PARK  = 2'd1,
        LANE_RUN   = 2'd2,
        LANE_DRAIN = 2'd3
    } lane_state_e;
endpackage

// File: rtl/clkmux_sync.sv
module clkmux_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Falling-edge re-timing so downstream gating moves while the clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clkmux_lane.sv
module clkmux_lane
    import clkmux_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int PARK_CYCLES  = 3,
    parameter int DRAIN_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic other_busy,
    output logic gate,
    output logic busy
);
    localparam int CNT_MAX = (PARK_CYCLES > DRAIN_CYCLES) ? PARK_CYCLES : DRAIN_CYCLES;
    localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);
    localparam logic [CNT_W-1:0] PARK_LAST  = CNT_W'(PARK_CYCLES - 1);
    localparam logic [CNT_W-1:0] DRAIN_LAST = CNT_W'(DRAIN_CYCLES - 1);

    lane_state_e      state, nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             want_s, other_s;

    clkmux_sync #(.STAGES(SYNC_STAGES)) u_want_sync (
        .clk(clk), .rst_n(rst_n), .d(want), .q(want_s)
    );

    clkmux_sync #(.STAGES(SYNC_STAGES)) u_other_sync (
        .clk(clk), .rst_n(rst_n), .d(other_busy), .q(other_s)
    );

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            LANE_IDLE: begin
                if (want_s && !other_s) begin
                    nxt     = LANE_PARK;
                    cnt_nxt = '0;
                end
            end
            LANE_PARK: begin
                if (!want_s || other_s) begin
                    nxt = LANE_IDLE;
                end else if (cnt == PARK_LAST) begin
                    nxt = LANE_RUN;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            LANE_RUN: begin
                if (!want_s) begin
                    nxt     = LANE_DRAIN;
                    cnt_nxt = '0;
                end
            end
            LANE_DRAIN: begin
                if (want_s) begin
                    nxt = LANE_RUN;
                end else if (cnt == DRAIN_LAST) begin
                    nxt = LANE_IDLE;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            default: nxt = LANE_IDLE;
        endcase
    end

    // State register
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LANE_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Registered outputs: clean gate and a clean busy for the other domain
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate <= 1'b0;
            busy <= 1'b0;
        end else begin
            gate <= (nxt == LANE_RUN) || (nxt == LANE_DRAIN);
            busy <= (nxt != LANE_IDLE);
        end
    end

    // R9
    gate_open_after_park_chk: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(gate) |-> ($past(state) == LANE_PARK && $past(cnt) == PARK_LAST));

    // R3
    gate_close_after_drain_chk: assert property (@(negedge clk) disable iff (!rst_n)
        $fell(gate) |-> ($past(state) == LANE_DRAIN && $past(cnt) == DRAIN_LAST));

    // R10
    drain_holds_gate_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (state == LANE_RUN && !want_s) |=> gate);
endmodule

// File: rtl/clk_switch2.sv
module clk_switch2 #(
    parameter int NUM_OUT      = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int PARK_CYCLES  = 3,
    parameter int DRAIN_CYCLES = 1
) (
    input  logic               clk_a,
    input  logic               clk_b,
    input  logic               rst_n,
    input  logic               pick_b,
    input  logic               a_stopped,
    input  logic               b_stopped,
    input  logic [NUM_OUT-1:0] copy_en,
    output logic [NUM_OUT-1:0] copy_clk
);
    logic gate_a, gate_b, busy_a, busy_b;
    logic lane_a_rst_n, lane_b_rst_n;
    logic muxed;

    // A stopped clock that is no longer wanted has its lane cleared at once
    assign lane_a_rst_n = rst_n & ~(a_stopped & pick_b);
    assign lane_b_rst_n = rst_n & ~(b_stopped & ~pick_b);

    clkmux_lane #(
        .SYNC_STAGES(SYNC_STAGES), .PARK_CYCLES(PARK_CYCLES), .DRAIN_CYCLES(DRAIN_CYCLES)
    ) u_lane_a (
        .clk(clk_a), .rst_n(lane_a_rst_n), .want(~pick_b),
        .other_busy(busy_b & ~b_stopped), .gate(gate_a), .busy(busy_a)
    );

    clkmux_lane #(
        .SYNC_STAGES(SYNC_STAGES), .PARK_CYCLES(PARK_CYCLES), .DRAIN_CYCLES(DRAIN_CYCLES)
    ) u_lane_b (
        .clk(clk_b), .rst_n(lane_b_rst_n), .want(pick_b),
        .other_busy(busy_a & ~a_stopped), .gate(gate_b), .busy(busy_b)
    );

    assign muxed = (clk_a & gate_a) | (clk_b & gate_b);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_copy
        assign copy_clk[i] = copy_en[i] & muxed;
    end

    // R6
    gates_exclusive_a_chk: assert property (@(negedge clk_a) disable iff (!rst_n)
        !(gate_a && gate_b));

    // R6
    gates_exclusive_b_chk: assert property (@(negedge clk_b) disable iff (!rst_n)
        !(gate_a && gate_b));
endmodule

// File: tb/tb_clk_switch2.sv
`timescale 1ns/1ps
module tb_clk_switch2;
    localparam int CLK_A_PERIOD = 10;
    localparam int CLK_B_PERIOD = 14;
    localparam int PARK         = 3;
    localparam int SYNC         = 2;
    localparam int MIN_HALF     = CLK_A_PERIOD / 2;

    logic       clk_a = 1'b0, clk_b = 1'b0;
    logic       run_a = 1'b1, run_b = 1'b1;
    logic       rst_n = 1'b0, pick_b = 1'b0;
    logic       a_stopped = 1'b0, b_stopped = 1'b0;
    logic [1:0] copy_en = 2'b11;
    logic [1:0] copy_clk;

    int     compared = 0, mismatched = 0;
    bit     mon_on = 0, last_valid = 0;
    longint last_edge = 0, last_fall = 0, last_rise = 0;
    longint max_gap = 0, last_hi_w = 0;

    clk_switch2 dut (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .pick_b(pick_b),
        .a_stopped(a_stopped), .b_stopped(b_stopped),
        .copy_en(copy_en), .copy_clk(copy_clk)
    );

    initial forever begin #(CLK_A_PERIOD/2); if (run_a) clk_a = ~clk_a; end
    initial forever begin #(CLK_B_PERIOD/2); if (run_b) clk_b = ~clk_b; end

    // Output pulse monitor on copy 0
    always @(copy_clk[0]) begin
        if (mon_on) begin
            if (last_valid) begin
                compared++;
                if ($time - last_edge < MIN_HALF) begin
                    mismatched++;
                    $display("FAIL R3 pulse width act=%0d exp>=%0d", $time - last_edge, MIN_HALF);
                end
            end
            last_valid = 1;
            last_edge  = $time;
        end
        if (copy_clk[0]) begin
            if ($time - last_fall > max_gap) max_gap = $time - last_fall;
            last_rise = $time;
        end else begin
            last_hi_w = $time - last_rise;
            last_fall = $time;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_ge(input string tag, input longint act, input longint lim);
        compared++;
        if (act < lim) begin
            mismatched++;
            $display("FAIL %s act=%0d exp>=%0d", tag, act, lim);
        end
    endtask

    // Compare both copies against the chosen source at times clear of edges
    task automatic follow(input string tag, input int n, input bit src_b);
        for (int k = 0; k < n; k++) begin
            #1;
            if (($time % (CLK_A_PERIOD/2)) != 0 && ($time % (CLK_B_PERIOD/2)) != 0) begin
                for (int i = 0; i < 2; i++) begin
                    chk(tag, copy_clk[i], copy_en[i] & (src_b ? clk_b : clk_a));
                end
            end
        end
    endtask

    task automatic switch_to(input bit s);
        int t_old = s ? CLK_A_PERIOD : CLK_B_PERIOD;
        int t_new = s ? CLK_B_PERIOD : CLK_A_PERIOD;
        max_gap = 0;
        pick_b  = s;
        follow("R10 old clock kept", SYNC * t_old - 1, !s);
        #(30 * t_new);
        chk_ge("R4 R9 low gap", max_gap, PARK * t_new);
        follow("R1 routing", 80, s);
        chk("R8 high width", last_hi_w, t_new / 2);
    endtask

    task automatic enable_sweep();
        mon_on = 0;
        for (int e = 0; e < 4; e++) begin
            copy_en = 2'(e);
            #20;
            follow("R7 copy enable", 40, pick_b);
        end
        copy_en = 2'b11;
        #20;
        last_valid = 0;
        mon_on = 1;
    endtask

    // Freeze the selected clock at level lvl, flag it, switch away
    task automatic dead_switch(input bit from_b, input bit lvl);
        int t_new = from_b ? CLK_A_PERIOD : CLK_B_PERIOD;
        if (!from_b) begin
            if (lvl) @(posedge clk_a); else @(negedge clk_a);
            run_a = 0;
        end else begin
            if (lvl) @(posedge clk_b); else @(negedge clk_b);
            run_b = 0;
        end
        #60;
        if (from_b) b_stopped = 1; else a_stopped = 1;
        #20;
        chk("R5 frozen level before switch", copy_clk[0], lvl);
        max_gap   = 0;
        last_fall = $time;
        pick_b    = ~from_b;
        #1;
        chk("R5 immediate low copy0", copy_clk[0], 0);
        chk("R5 immediate low copy1", copy_clk[1], 0);
        #(30 * t_new);
        chk_ge("R4 gap after dead switch", max_gap, PARK * t_new);
        follow("R1 routing after dead switch", 60, ~from_b);
        if (from_b) run_b = 1; else run_a = 1;
        #30;
        if (from_b) b_stopped = 0; else a_stopped = 0;
        #300;
        follow("R6 revived clock stays out", 80, ~from_b);
    endtask

    initial begin
        #50;
        chk("R2 reset copy0 low", copy_clk[0], 0);
        chk("R2 reset copy1 low", copy_clk[1], 0);
        #3;
        rst_n     = 1;
        last_fall = $time;
        max_gap   = 0;
        mon_on    = 1;
        #400;
        chk_ge("R2 first pulse delay", max_gap, PARK * CLK_A_PERIOD);
        follow("R1 routing A after reset", 80, 0);
        chk("R8 high width A", last_hi_w, CLK_A_PERIOD / 2);
        switch_to(1);
        switch_to(0);
        switch_to(1);
        enable_sweep();
        switch_to(0);
        enable_sweep();
        dead_switch(0, 1);
        dead_switch(1, 0);
        dead_switch(0, 0);
        dead_switch(1, 1);
        switch_to(1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #1000000;
        mismatched++;
        $display("FAIL watchdog act=hung exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule